// File: doc/BRIEF.md
# Page-Buffered Log Writer

This block sits between a stream of log bytes and a nonvolatile memory that can only be programmed a whole page at a time. Incoming bytes fill a one-page staging buffer. When the buffer holds a full page, the block issues a single page-program command at a page-aligned byte address. The memory side then pulls the page contents through a read port into the staging buffer. Partial pages are never programmed.

The last page of the memory is reserved for three small bookkeeping fields. A logging session starts with a pulse on `sess_start`. The block then fetches the fields over a byte-wide metadata port and resumes writing at the saved page. On a `sess_end` pulse the block rewrites the fields so that the next session starts on the page after the last one it filled. The fields also record where this session began and how many pages it filled. Writing stops for good after the page just below the reserved page. From then on the input stays blocked until the session is closed.

Top module: `log_page_writer`

## Requirements
- R1: After reset `in_ready`, `pw_req`, `md_req`, `full` and `drop_count` are all 0.
- R2: Each session start reads the reserved page through the metadata port before `in_ready` rises. It reads offsets 0 to 5 and nothing else. The layout holds three 2-byte little-endian fields: offsets 0-1 hold the session's first page, offsets 2-3 hold the resume page, and offsets 4-5 hold the number of pages filled.
- R3: Writing begins at the loaded resume page. A resume value of `NUM_PAGES-1` or more, including the erased value 0xFFFF, begins at page 0 instead.
- R4: `pw_req` rises only after `PAGE_BYTES` bytes have been accepted. While it is high, `pw_addr` equals page × `PAGE_BYTES` and stays stable until `pw_done`. Buffer offset i returns the i-th byte of that page.
- R5: `in_ready` is low from the cycle after the last byte of a page until the cycle after `pw_done`. Each later page goes to the next page number.
- R6: After `pw_done` for page `NUM_PAGES-2`, `full` is 1 and `in_ready` stays low. No further page command is issued in that session.
- R7: On close the block writes offsets 0 to 5 with three values: the page this session began on, the next page to fill (0 when `full`), and the count of pages programmed in this session.
- R8: Bytes left in a partly filled buffer at close are discarded and never programmed. `drop_count` shows how many there were.
- R9: A byte accepted in the same cycle as `sess_end` still counts. If it completes a page, that page is programmed before the close and `drop_count` is 0.
- R10: A `sess_end` pulse that arrives while a page program is pending is remembered. The close then follows `pw_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sess_start | input | 1 | Pulse: open a logging session |
| sess_end | input | 1 | Pulse: close the logging session |
| in_valid | input | 1 | Log byte valid |
| in_data | input | 8 | Log byte |
| in_ready | output | 1 | Log byte accepted when high with `in_valid` |
| pw_req | output | 1 | Page-program command pending |
| pw_addr | output | ADDR_W | Page-aligned byte address of the command |
| pw_done | input | 1 | Pulse: page program finished |
| buf_raddr | input | OFF_W | Staging-buffer read offset |
| buf_rdata | output | 8 | Staging-buffer byte at `buf_raddr` |
| md_req | output | 1 | Metadata byte access pending |
| md_we | output | 1 | 1 = write, 0 = read |
| md_addr | output | OFF_W | Byte offset inside the reserved page |
| md_wdata | output | 8 | Metadata write byte |
| md_rdata | input | 8 | Metadata read byte, valid with `md_ack` |
| md_ack | input | 1 | Pulse: metadata access complete |
| full | output | 1 | Last data page has been programmed |
| drop_count | output | OFF_W | Bytes discarded at the last close |

## Verification
Two events can fall in the same cycle: the close request and the acceptance of the byte that completes a page. The bench provokes this by driving `sess_end` together with `in_valid` on the 256th byte of a page. It then expects a page program at the next address first and the metadata rewrite after `pw_done`, with a drop count of 0. A second case raises `sess_end` while the program is still pending and applies the same judgement. A reference model in the bench tracks, clock by clock, which cycles must show `pw_req` and at which address. It compares every programmed page byte for byte with the bytes it has seen accepted.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_COLLECT,
        ST_PROGRAM,
        ST_STORE
    } lpw_state_e;

    // Field order inside the reserved page; the memory image depends on it.
    localparam int FLD_FIRST  = 0;
    localparam int FLD_RESUME = 1;
    localparam int FLD_COUNT  = 2;
    localparam int NUM_FIELDS = 3;

endpackage

// File: rtl/lpw_page_buf.sv
module lpw_page_buf #(
    parameter int PAGE_BYTES = 256,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [OFF_W-1:0] rd_addr,
    output logic [7:0]       rd_data
);

    logic [7:0] mem_q [PAGE_BYTES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/lpw_meta_xfer.sv
module lpw_meta_xfer #(
    parameter int FIELD_BYTES = 2,
    parameter int MA_W        = 8,
    localparam int NB         = lpw_pkg::NUM_FIELDS * FIELD_BYTES,
    localparam int IDX_W      = $clog2(NB),
    localparam int FLAT_W     = NB * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_rd,
    input  logic              start_wr,
    input  logic [FLAT_W-1:0] wr_flat,
    output logic [FLAT_W-1:0] rd_flat,
    output logic              done,
    output logic              md_req,
    output logic              md_we,
    output logic [MA_W-1:0]   md_addr,
    output logic [7:0]        md_wdata,
    input  logic [7:0]        md_rdata,
    input  logic              md_ack
);

    typedef struct packed {
        logic              busy;
        logic              we;
        logic [IDX_W-1:0]  idx;
        logic              done;
        logic [FLAT_W-1:0] rbytes;
    } xfer_s;

    xfer_s s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start_rd || start_wr) begin
                s_d.busy = 1'b1;
                s_d.we   = start_wr;
                s_d.idx  = '0;
            end
        end else if (md_ack) begin
            if (!s_q.we) begin
                s_d.rbytes[s_q.idx*8 +: 8] = md_rdata;
            end
            if (s_q.idx == IDX_W'(NB - 1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign md_req   = s_q.busy;
    assign md_we    = s_q.we;
    assign md_addr  = MA_W'(s_q.idx);
    assign md_wdata = wr_flat[s_q.idx*8 +: 8];
    assign rd_flat  = s_q.rbytes;
    assign done     = s_q.done;

endmodule

// File: rtl/log_page_writer.sv
module log_page_writer #(
    parameter int NUM_PAGES   = 8,
    parameter int PAGE_BYTES  = 256,
    parameter int FIELD_BYTES = 2,
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int PG_W       = $clog2(NUM_PAGES),
    localparam int ADDR_W     = PG_W + OFF_W,
    localparam int FW         = 8 * FIELD_BYTES,
    localparam int FLAT_W     = lpw_pkg::NUM_FIELDS * FW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sess_start,
    input  logic              sess_end,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              pw_req,
    output logic [ADDR_W-1:0] pw_addr,
    input  logic              pw_done,
    input  logic [OFF_W-1:0]  buf_raddr,
    output logic [7:0]        buf_rdata,
    output logic              md_req,
    output logic              md_we,
    output logic [OFF_W-1:0]  md_addr,
    output logic [7:0]        md_wdata,
    input  logic [7:0]        md_rdata,
    input  logic              md_ack,
    output logic              full,
    output logic [OFF_W-1:0]  drop_count
);
    import lpw_pkg::*;

    localparam logic [PG_W-1:0]  LAST_DATA = PG_W'(NUM_PAGES - 2);
    localparam logic [PG_W-1:0]  RESERVED  = PG_W'(NUM_PAGES - 1);
    localparam logic [OFF_W-1:0] PTR_LAST  = OFF_W'(PAGE_BYTES - 1);

    typedef struct packed {
        lpw_state_e       st;
        logic [PG_W-1:0]  cur_page;
        logic [PG_W-1:0]  first_page;
        logic [PG_W-1:0]  pages_done;
        logic [OFF_W-1:0] ptr;
        logic             end_pend;
        logic             full;
        logic [OFF_W-1:0] drop;
    } ctl_s;

    ctl_s c_d, c_q;

    logic              accept;
    logic              start_rd, start_wr, xfer_done;
    logic [FLAT_W-1:0] rd_flat, wr_flat;
    logic [FW-1:0]     resume_fld;
    logic [PG_W-1:0]   resume_page;
    logic [PG_W-1:0]   next_page;

    assign in_ready = (c_q.st == ST_COLLECT) && !c_q.full;
    assign accept   = in_valid && in_ready;

    // Loaded resume page: out-of-range values (erased memory included) restart at 0.
    assign resume_fld  = rd_flat[FLD_RESUME*FW +: FW];
    assign resume_page = (resume_fld >= FW'(NUM_PAGES - 1)) ? '0 : resume_fld[PG_W-1:0];

    assign next_page = (c_q.cur_page == RESERVED) ? '0 : c_q.cur_page;

    always_comb begin
        wr_flat = '0;
        wr_flat[FLD_FIRST*FW  +: FW] = FW'(c_q.first_page);
        wr_flat[FLD_RESUME*FW +: FW] = FW'(next_page);
        wr_flat[FLD_COUNT*FW  +: FW] = FW'(c_q.pages_done);
    end

    always_comb begin
        c_d      = c_q;
        start_rd = 1'b0;
        start_wr = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (sess_start) begin
                    c_d.st   = ST_LOAD;
                    start_rd = 1'b1;
                end
            end
            ST_LOAD: begin
                if (xfer_done) begin
                    c_d.st         = ST_COLLECT;
                    c_d.cur_page   = resume_page;
                    c_d.first_page = resume_page;
                    c_d.pages_done = '0;
                    c_d.ptr        = '0;
                    c_d.full       = 1'b0;
                    c_d.end_pend   = 1'b0;
                end
            end
            ST_COLLECT: begin
                if (accept) begin
                    if (c_q.ptr == PTR_LAST) begin
                        c_d.st       = ST_PROGRAM;
                        c_d.ptr      = '0;
                        c_d.end_pend = sess_end;
                    end else begin
                        c_d.ptr = c_q.ptr + 1'b1;
                        if (sess_end) begin
                            c_d.st   = ST_STORE;
                            c_d.drop = c_q.ptr + 1'b1;
                            start_wr = 1'b1;
                        end
                    end
                end else if (sess_end) begin
                    c_d.st   = ST_STORE;
                    c_d.drop = c_q.ptr;
                    start_wr = 1'b1;
                end
            end
            ST_PROGRAM: begin
                if (sess_end) begin
                    c_d.end_pend = 1'b1;
                end
                if (pw_done) begin
                    c_d.pages_done = c_q.pages_done + 1'b1;
                    c_d.cur_page   = c_q.cur_page + 1'b1;
                    if (c_q.cur_page == LAST_DATA) begin
                        c_d.full = 1'b1;
                    end
                    if (c_q.end_pend || sess_end) begin
                        c_d.st   = ST_STORE;
                        c_d.drop = '0;
                        start_wr = 1'b1;
                    end else begin
                        c_d.st = ST_COLLECT;
                    end
                end
            end
            ST_STORE: begin
                if (xfer_done) begin
                    c_d.st = ST_IDLE;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign pw_req     = (c_q.st == ST_PROGRAM);
    assign pw_addr    = {c_q.cur_page, {OFF_W{1'b0}}};
    assign full       = c_q.full;
    assign drop_count = c_q.drop;

    lpw_page_buf #(
        .PAGE_BYTES (PAGE_BYTES)
    ) u_buf (
        .clk     (clk),
        .wr_en   (accept),
        .wr_addr (c_q.ptr),
        .wr_data (in_data),
        .rd_addr (buf_raddr),
        .rd_data (buf_rdata)
    );

    lpw_meta_xfer #(
        .FIELD_BYTES (FIELD_BYTES),
        .MA_W        (OFF_W)
    ) u_meta (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_rd (start_rd),
        .start_wr (start_wr),
        .wr_flat  (wr_flat),
        .rd_flat  (rd_flat),
        .done     (xfer_done),
        .md_req   (md_req),
        .md_we    (md_we),
        .md_addr  (md_addr),
        .md_wdata (md_wdata),
        .md_rdata (md_rdata),
        .md_ack   (md_ack)
    );

endmodule

// File: rtl/lpw_chk.sv
module lpw_chk #(
    parameter int NUM_PAGES   = 8,
    parameter int PAGE_BYTES  = 256,
    parameter int FIELD_BYTES = 2,
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int ADDR_W     = $clog2(NUM_PAGES) + OFF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              pw_req,
    input logic [ADDR_W-1:0] pw_addr,
    input logic              pw_done,
    input logic              md_req,
    input logic [OFF_W-1:0]  md_addr,
    input logic              full
);

    a_r4_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        pw_req |-> (pw_addr[OFF_W-1:0] == '0));

    a_r4_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_req && !pw_done) |=> (pw_req && $stable(pw_addr)));

    a_r5_no_ready_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
        pw_req |-> !in_ready);

    a_r6_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (!in_ready && !pw_req));

    a_r6_skip_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        pw_req |-> (32'(pw_addr) < (NUM_PAGES - 1) * PAGE_BYTES));

    a_r6_full_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(pw_done));

    a_r2_md_window: assert property (@(posedge clk) disable iff (!rst_n)
        md_req |-> ((32'(md_addr) < 3 * FIELD_BYTES) && !in_ready && !pw_req));

endmodule

bind log_page_writer lpw_chk #(
    .NUM_PAGES   (NUM_PAGES),
    .PAGE_BYTES  (PAGE_BYTES),
    .FIELD_BYTES (FIELD_BYTES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .pw_req   (pw_req),
    .pw_addr  (pw_addr),
    .pw_done  (pw_done),
    .md_req   (md_req),
    .md_addr  (md_addr),
    .full     (full)
);

// File: tb/test_log_page_writer.sv
module test_log_page_writer;

    localparam int NP     = 8;
    localparam int PB     = 256;
    localparam int FB     = 2;
    localparam int OFF_W  = $clog2(PB);
    localparam int ADDR_W = $clog2(NP) + OFF_W;
    localparam int NMD    = 3 * FB;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sess_start = 1'b0, sess_end = 1'b0;
    logic              in_valid = 1'b0;
    logic [7:0]        in_data = '0;
    logic              in_ready;
    logic              pw_req;
    logic [ADDR_W-1:0] pw_addr;
    logic              pw_done = 1'b0;
    logic [OFF_W-1:0]  buf_raddr = '0;
    logic [7:0]        buf_rdata;
    logic              md_req, md_we;
    logic [OFF_W-1:0]  md_addr;
    logic [7:0]        md_wdata;
    logic [7:0]        md_rdata = '0;
    logic              md_ack = 1'b0;
    logic              full;
    logic [OFF_W-1:0]  drop_count;

    // 125 MHz: 8 time units per period
    always #4 clk = ~clk;

    log_page_writer #(.NUM_PAGES(NP), .PAGE_BYTES(PB), .FIELD_BYTES(FB)) i_log_page_writer (
        .clk(clk), .rst_n(rst_n), .sess_start(sess_start), .sess_end(sess_end),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .pw_req(pw_req), .pw_addr(pw_addr), .pw_done(pw_done),
        .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
        .md_req(md_req), .md_we(md_we), .md_addr(md_addr), .md_wdata(md_wdata),
        .md_rdata(md_rdata), .md_ack(md_ack), .full(full), .drop_count(drop_count)
    );

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- behavioural memory image ----------------
    logic [7:0] meta [NMD];
    int md_rd_cnt = 0;
    int md_wr_cnt = 0;
    int md_bad = 0;

    initial forever begin
        @(negedge clk);
        if (md_ack) begin
            md_ack = 1'b0;
        end else if (md_req) begin
            md_ack = 1'b1;
            if (int'(md_addr) >= NMD) begin
                md_bad++;
            end else if (md_we) begin
                meta[md_addr] = md_wdata;
                md_wr_cnt++;
            end else begin
                md_rdata = meta[md_addr];
                md_rd_cnt++;
            end
        end
    end

    // ---------------- reference model ----------------
    byte unsigned cur_q[$];
    byte unsigned page_q[$];
    int  m_page, m_first, m_pages;
    bit  m_prog, m_full;
    bit  mon_en = 1'b0;
    int  pages_seen = 0;

    initial forever begin
        @(negedge clk);
        #1;
        if (mon_en) begin
            chk(pw_req == m_prog, "R4 pw_req timing", int'(pw_req), int'(m_prog));
            if (pw_req)
                chk(int'(pw_addr) == m_page * PB, "R4 pw_addr", int'(pw_addr), m_page * PB);
            if (m_prog || m_full)
                chk(!in_ready, "R5 ready while page pending or full", int'(in_ready), 0);
            if (m_full)
                chk(full == 1'b1, "R6 full flag", int'(full), 1);
            if (in_valid && in_ready) begin
                cur_q.push_back(in_data);
                if (cur_q.size() == PB) begin
                    m_prog = 1'b1;
                    foreach (cur_q[i]) page_q.push_back(cur_q[i]);
                    cur_q.delete();
                end
            end
            if (pw_done) begin
                m_prog = 1'b0;
                if (m_page == NP - 2) m_full = 1'b1;
                m_page++;
                m_pages++;
            end
        end
    end

    // ---------------- page program responder ----------------
    initial forever begin
        @(negedge clk);
        if (pw_req && !pw_done) begin
            bit ok = 1'b1;
            int bad_at = -1;
            int got = 0, want = 0;
            for (int k = 0; k < PB; k++) begin
                buf_raddr = OFF_W'(k);
                @(negedge clk);
                want = (page_q.size() > 0) ? int'(page_q.pop_front()) : -1;
                if (ok && int'(buf_rdata) != want) begin
                    ok = 1'b0; bad_at = k; got = int'(buf_rdata);
                end
            end
            if (bad_at >= 0) want = want;
            chk(ok, "R4 page content in arrival order", got, want);
            pages_seen++;
            pw_done = 1'b1;
            @(negedge clk);
            pw_done = 1'b0;
        end
    end

    // ---------------- stimulus helpers ----------------
    int seed = 5;

    task automatic send_byte(input bit with_end);
        in_data  = 8'((seed * 37 + 11) & 255);
        seed++;
        in_valid = 1'b1;
        sess_end = with_end;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        sess_end = 1'b0;
    endtask

    task automatic send_bytes(input int n);
        for (int i = 0; i < n; i++) send_byte(1'b0);
    endtask

    task automatic set_meta(input int first, input int resume, input int cnt);
        meta[0] = 8'(first); meta[1] = 8'(first >> 8);
        meta[2] = 8'(resume); meta[3] = 8'(resume >> 8);
        meta[4] = 8'(cnt); meta[5] = 8'(cnt >> 8);
    endtask

    task automatic open_session(input string req);
        int rv;
        rv = int'(meta[2]) | (int'(meta[3]) << 8);
        m_page  = (rv >= NP - 1) ? 0 : rv;
        m_first = m_page;
        m_pages = 0;
        m_prog  = 1'b0;
        m_full  = 1'b0;
        cur_q.delete();
        md_rd_cnt = 0;
        md_wr_cnt = 0;
        sess_start = 1'b1;
        @(negedge clk);
        sess_start = 1'b0;
        while (!in_ready) @(negedge clk);
        chk(md_rd_cnt == NMD, "R2 reserved bytes read before ready", md_rd_cnt, NMD);
        chk(md_wr_cnt == 0, "R2 no metadata write at open", md_wr_cnt, 0);
        chk(full == 1'b0, {req, " full clear at open"}, int'(full), 0);
    endtask

    task automatic wait_close(input string req);
        int e_wr, e_drop;
        while (md_wr_cnt < NMD) @(negedge clk);
        repeat (4) @(negedge clk);
        e_wr   = (m_page == NP - 1) ? 0 : m_page;
        e_drop = cur_q.size();
        chk(int'(meta[0]) == m_first && meta[1] == 0, {req, " R7 first page field"}, int'(meta[0]), m_first);
        chk(int'(meta[2]) == e_wr && meta[3] == 0, {req, " R7 resume field"}, int'(meta[2]), e_wr);
        chk(int'(meta[4]) == m_pages && meta[5] == 0, {req, " R7 count field"}, int'(meta[4]), m_pages);
        chk(int'(drop_count) == e_drop, {req, " R8 drop_count"}, int'(drop_count), e_drop);
        chk(!in_ready && !md_req && !pw_req, {req, " idle after close"}, int'(in_ready), 0);
        cur_q.delete();
    endtask

    // ---------------- test sequence ----------------
    initial begin
        for (int i = 0; i < NMD; i++) meta[i] = 8'hFF;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!in_ready && !pw_req && !md_req, "R1 handshakes low in reset", int'({in_ready, pw_req, md_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(full == 1'b0 && drop_count == '0, "R1 full/drop after reset", int'(drop_count), 0);
        mon_en = 1'b1;

        // Erased image: R3 start at page 0; two pages then a partial page
        open_session("R3 erased");
        send_bytes(2 * PB + 10);
        @(negedge clk);
        sess_end = 1'b1;
        @(negedge clk);
        sess_end = 1'b0;
        wait_close("R8 partial");

        // R9: sess_end together with the last byte of a page
        open_session("R3 resume");
        chk(m_first == 2, "R3 resume page from image", m_first, 2);
        send_bytes(PB - 1);
        send_byte(1'b1);
        wait_close("R9 same cycle");
        chk(pages_seen == 3, "R9 page programmed before close", pages_seen, 3);

        // R10: sess_end while a program is pending
        open_session("R10");
        send_bytes(PB);
        while (!pw_req) @(negedge clk);
        repeat (3) @(negedge clk);
        sess_end = 1'b1;
        @(negedge clk);
        sess_end = 1'b0;
        chk(md_wr_cnt == 0 && pw_req, "R10 close waits for pw_done", md_wr_cnt, 0);
        wait_close("R10 pending end");

        // R6: fill up to the page below the reserved one
        open_session("R6");
        send_bytes(3 * PB);
        while (!full) @(negedge clk);
        in_valid = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk(!in_ready && !pw_req, "R6 input blocked when full", int'(in_ready), 0);
        end
        in_valid = 1'b0;
        chk(m_page == NP - 1, "R6 stop after penultimate page", m_page, NP - 1);
        sess_end = 1'b1;
        @(negedge clk);
        sess_end = 1'b0;
        wait_close("R6 full close");

        // R3: resume value pointing at the reserved page restarts at 0
        set_meta(4, NP - 1, 3);
        open_session("R3 wrap");
        chk(m_first == 0, "R3 wrap to page 0", m_first, 0);
        send_bytes(PB + 3);
        repeat (2) @(negedge clk);
        sess_end = 1'b1;
        @(negedge clk);
        sess_end = 1'b0;
        wait_close("R8 wrap partial");

        chk(md_bad == 0, "R2 metadata offsets within fields", md_bad, 0);
        chk(page_q.size() == 0, "R4 every full page programmed", page_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule